// File: doc/BRIEF.md
# Multiply / Divide / Multiply-Accumulate Coprocessor

This block is a multi-cycle arithmetic unit placed next to a 16-bit processor. The processor presents two operands, an accumulator value, an operation code and a sign-mode bit, then raises `start` for one cycle. The block captures everything on that edge and raises `busy`. It runs one shared iterative engine for a fixed number of cycles that depends on the operation. It then writes its result registers and pulses `done`.

The engine retires several multiplier bits per cycle for the 16x16 product. For division it runs a chain of restoring subtract-and-shift steps and uses more or fewer of them per cycle, so that every operation takes a fixed latency. Signed operations run on magnitudes, and the sign is restored in the final cycle. The same final stage adds the accumulator and, for the saturating accumulate, clamps the sum.

Top module: `arith_coproc`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `res`, `rem`, `dz` and `ovf` are all zero.
- R2: A start taken while idle raises `busy` on the next cycle. `busy` then stays high for exactly 4 cycles (op 0, 3, 4), 8 cycles (op 1) or 16 cycles (op 2). `done` is high for exactly one cycle, which is the first cycle with `busy` low again.
- R3: Operation codes on `op` are: 0 multiply, 1 divide `opa` by the 16-bit `opb[15:0]`, 2 divide `opa` by the 32-bit `opb`, 3 wrapping multiply-accumulate, 4 saturating multiply-accumulate. A start with codes 5 to 7 is ignored: `busy` stays low and no result changes.
- R4: Multiply gives `res` = `opa[15:0]` x `opb[15:0]` as a 32-bit product. The operands are two's complement when `sgn`=1 and unsigned when `sgn`=0. `rem`, `dz` and `ovf` are 0.
- R5: Unsigned division (`sgn`=0) with a nonzero divisor gives the quotient in `res` and the remainder in `rem`, with `dz`=0 and `ovf`=0. For op 1 the divisor is zero-extended.
- R6: Signed division (`sgn`=1) truncates the quotient toward zero, and the remainder carries the sign of the dividend. For op 1 the divisor is sign-extended from bit 15. A quotient of +2^31 (only -2^31 / -1) returns 0x80000000 with `ovf`=1.
- R7: A zero divisor sets `dz`=1, gives `res`=0xFFFFFFFF and `rem`=`opa`, and still takes the normal latency. Any later completed operation with a nonzero divisor, or one that is not a division, clears `dz`.
- R8: Wrapping accumulate gives `res` as the low 32 bits of the product plus `acc_in`. The product is signed or unsigned as in R4, and `acc_in` is sign- or zero-extended to match. `ovf`=1 when the exact sum falls outside the 32-bit range of that mode. `rem`=0.
- R9: Saturating accumulate gives the same sum and `ovf` as R8. When the sum is out of range, `res` is clamped: to 0x7FFFFFFF if it is too high in signed mode, to 0x80000000 if it is too low in signed mode, and to 0xFFFFFFFF in unsigned mode.
- R10: `start` is ignored while `busy` is high. Operand, code and mode changes after the accepted start have no effect on the result.
- R11: `res`, `rem`, `dz` and `ovf` change only on a `done` cycle and hold their values between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 3 | Operation code |
| sgn | input | 1 | 1 = two's complement, 0 = unsigned |
| opa | input | 32 | Multiplicand (low 16 bits) or dividend |
| opb | input | 32 | Multiplier (low 16 bits) or divisor |
| acc_in | input | 32 | Accumulator addend for ops 3 and 4 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res | output | 32 | Product, quotient or accumulated sum |
| rem | output | 32 | Division remainder |
| dz | output | 1 | Divide-by-zero flag |
| ovf | output | 1 | Overflow / clamp flag |

## Verification
Multiply and both accumulate forms are swept over every pair from a set of 16-bit corner values: zero, one, the signed extremes, all ones and mixed patterns. Accumulate also crosses these pairs with the 32-bit accumulator extremes, so wrap and clamp in each direction and in both modes are told apart from in-range sums. Both division widths run over a cross of 32-bit corner dividends and divisors, which covers zero divisors, -1, the most negative value and mixed signs. This separates truncation toward zero and the sign of the remainder from floor-style results, and the 16-bit divisor extension from the 32-bit path. Random operands then add spread, and dedicated sequences cover rejected codes, a start issued mid-operation and result hold.

// File: rtl/arcop_pkg.sv
package arcop_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_DIVS = 3'd1,
    OP_DIVL = 3'd2,
    OP_MACW = 3'd3,
    OP_MACS = 3'd4
  } arc_op_e;
endpackage

// File: rtl/arcop_mul_step.sv
// One multiply iteration: shift the running product left by NB and add
// the magnitude multiplicand times the next NB multiplier bits (MSB first).
module arcop_mul_step #(
  parameter int W  = 16,
  parameter int NB = 4
) (
  input  logic [2*W-1:0] p_in,
  input  logic [W-1:0]   a,
  input  logic [NB-1:0]  dig,
  output logic [2*W-1:0] p_out
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] part [NB];

  generate
    for (genvar i = 0; i < NB; i++) begin : g_pp
      assign part[i] = dig[i] ? (W2'(a) << i) : '0;
    end
  endgenerate

  always_comb begin
    p_out = p_in << NB;
    for (int i = 0; i < NB; i++) p_out = p_out + part[i];
  end
endmodule

// File: rtl/arcop_div_chain.sv
// Chain of restoring division steps. Tap A after KA steps, tap B after KB.
module arcop_div_chain #(
  parameter int DW = 32,
  parameter int KA = 4,
  parameter int KB = 2
) (
  input  logic [DW-1:0] d,
  input  logic [DW-1:0] r_in,
  input  logic [DW-1:0] q_in,
  output logic [DW-1:0] r_a,
  output logic [DW-1:0] q_a,
  output logic [DW-1:0] r_b,
  output logic [DW-1:0] q_b
);
  localparam int K = (KA > KB) ? KA : KB;

  logic [DW-1:0] rs [K+1];
  logic [DW-1:0] qs [K+1];

  assign rs[0] = r_in;
  assign qs[0] = q_in;

  generate
    for (genvar k = 0; k < K; k++) begin : g_st
      logic [DW:0] sh;
      logic [DW:0] df;
      assign sh = {rs[k], qs[k][DW-1]};
      assign df = sh - {1'b0, d};
      assign rs[k+1] = df[DW] ? sh[DW-1:0] : df[DW-1:0];
      assign qs[k+1] = {qs[k][DW-2:0], ~df[DW]};
    end
  endgenerate

  assign r_a = rs[KA];
  assign q_a = qs[KA];
  assign r_b = rs[KB];
  assign q_b = qs[KB];
endmodule

// File: rtl/arcop_finish.sv
// Final stage: restore signs, accumulate, clamp, and build the flags.
module arcop_finish
  import arcop_pkg::*;
#(
  parameter int W2 = 32
) (
  input  arc_op_e        op,
  input  logic           sgn,
  input  logic [W2-1:0]  pm,
  input  logic           negp,
  input  logic [W2-1:0]  acc,
  input  logic [W2-1:0]  qm,
  input  logic [W2-1:0]  rm,
  input  logic           negq,
  input  logic           negr,
  input  logic           dz,
  input  logic [W2-1:0]  dvd,
  output logic [W2-1:0]  res,
  output logic [W2-1:0]  rem,
  output logic           ovf
);
  logic [W2-1:0] prod;
  logic [W2+1:0] pe, ae, sum;
  logic          mac_ovf;
  logic [W2-1:0] clamp;

  always_comb begin
    prod    = negp ? (~pm + 1'b1) : pm;
    pe      = sgn ? {{2{prod[W2-1]}}, prod} : {2'b00, prod};
    ae      = sgn ? {{2{acc[W2-1]}}, acc} : {2'b00, acc};
    sum     = pe + ae;
    mac_ovf = sgn ? ((sum[W2+1:W2-1] != 3'b000) && (sum[W2+1:W2-1] != 3'b111))
                  : sum[W2];
    if (!sgn)           clamp = '1;
    else if (sum[W2+1]) clamp = {1'b1, {(W2-1){1'b0}}};
    else                clamp = {1'b0, {(W2-1){1'b1}}};

    res = '0;
    rem = '0;
    ovf = 1'b0;
    case (op)
      OP_MUL: res = prod;
      OP_DIVS, OP_DIVL: begin
        if (dz) begin
          res = '1;
          rem = dvd;
        end else begin
          res = negq ? (~qm + 1'b1) : qm;
          rem = negr ? (~rm + 1'b1) : rm;
          ovf = sgn && !negq && qm[W2-1];
        end
      end
      OP_MACW: begin
        res = sum[W2-1:0];
        ovf = mac_ovf;
      end
      OP_MACS: begin
        res = mac_ovf ? clamp : sum[W2-1:0];
        ovf = mac_ovf;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/arith_coproc.sv
module arith_coproc
  import arcop_pkg::*;
#(
  parameter int W        = 16,
  parameter int MUL_CYC  = 4,
  parameter int DIVS_CYC = 8,
  parameter int DIVL_CYC = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic           sgn,
  input  logic [2*W-1:0] opa,
  input  logic [2*W-1:0] opb,
  input  logic [2*W-1:0] acc_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] res,
  output logic [2*W-1:0] rem,
  output logic           dz,
  output logic           ovf
);
  localparam int W2   = 2 * W;
  localparam int MB   = W / MUL_CYC;
  localparam int KS   = W2 / DIVS_CYC;
  localparam int KL   = W2 / DIVL_CYC;
  localparam int LM1  = (MUL_CYC > DIVS_CYC) ? MUL_CYC : DIVS_CYC;
  localparam int LMAX = (LM1 > DIVL_CYC) ? LM1 : DIVL_CYC;
  localparam int CW   = $clog2(LMAX + 1);

  // ---------------- state ----------------
  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;
  arc_op_e       op_q;
  logic          sgn_q, negp_q, negq_q, negr_q, dzp_q;
  logic [W-1:0]  ma_q, mb_q;
  logic [W2-1:0] p_q, rq, qq, dq, acc_q, dvd_q;
  logic [W2-1:0] res_q, rem_q;
  logic          dz_q, ovf_q;

  // ---------------- operand capture ----------------
  logic          accept, op_ok;
  logic [W-1:0]  a_lo, b_lo, a_mag, b_mag;
  logic          a_s, b_s;
  logic [W2-1:0] dvr, dvd_mag, dvr_mag;
  logic          dvd_s, dvr_s;
  logic [CW-1:0] lat_m1;

  always_comb begin
    op_ok   = (op <= 3'd4);
    accept  = start && !busy_q && op_ok;
    a_lo    = opa[W-1:0];
    b_lo    = opb[W-1:0];
    a_s     = sgn && a_lo[W-1];
    b_s     = sgn && b_lo[W-1];
    a_mag   = a_s ? (~a_lo + 1'b1) : a_lo;
    b_mag   = b_s ? (~b_lo + 1'b1) : b_lo;
    if (op == OP_DIVS) dvr = sgn ? {{W{b_lo[W-1]}}, b_lo} : {{W{1'b0}}, b_lo};
    else               dvr = opb;
    dvd_s   = sgn && opa[W2-1];
    dvr_s   = sgn && dvr[W2-1];
    dvd_mag = dvd_s ? (~opa + 1'b1) : opa;
    dvr_mag = dvr_s ? (~dvr + 1'b1) : dvr;
    case (op)
      OP_DIVS: lat_m1 = CW'(DIVS_CYC - 1);
      OP_DIVL: lat_m1 = CW'(DIVL_CYC - 1);
      default: lat_m1 = CW'(MUL_CYC - 1);
    endcase
  end

  // ---------------- shared engine ----------------
  logic [W2-1:0] p_nx, r_s, q_s, r_l, q_l, r_nx, q_nx;

  arcop_mul_step #(.W(W), .NB(MB)) u_mul (
    .p_in (p_q),
    .a    (ma_q),
    .dig  (mb_q[W-1 -: MB]),
    .p_out(p_nx)
  );

  arcop_div_chain #(.DW(W2), .KA(KS), .KB(KL)) u_div (
    .d   (dq),
    .r_in(rq),
    .q_in(qq),
    .r_a (r_s),
    .q_a (q_s),
    .r_b (r_l),
    .q_b (q_l)
  );

  assign r_nx = (op_q == OP_DIVS) ? r_s : r_l;
  assign q_nx = (op_q == OP_DIVS) ? q_s : q_l;

  logic [W2-1:0] fin_res, fin_rem;
  logic          fin_ovf;

  arcop_finish #(.W2(W2)) u_fin (
    .op  (op_q),
    .sgn (sgn_q),
    .pm  (p_nx),
    .negp(negp_q),
    .acc (acc_q),
    .qm  (q_nx),
    .rm  (r_nx),
    .negq(negq_q),
    .negr(negr_q),
    .dz  (dzp_q),
    .dvd (dvd_q),
    .res (fin_res),
    .rem (fin_rem),
    .ovf (fin_ovf)
  );

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;  done_q <= 1'b0;  cnt_q <= '0;
      op_q   <= OP_MUL; sgn_q <= 1'b0;
      negp_q <= 1'b0;  negq_q <= 1'b0; negr_q <= 1'b0; dzp_q <= 1'b0;
      ma_q   <= '0;    mb_q   <= '0;   p_q    <= '0;
      rq     <= '0;    qq     <= '0;   dq     <= '0;
      acc_q  <= '0;    dvd_q  <= '0;
      res_q  <= '0;    rem_q  <= '0;   dz_q   <= 1'b0; ovf_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_m1;
        op_q   <= arc_op_e'(op);
        sgn_q  <= sgn;
        ma_q   <= a_mag;
        mb_q   <= b_mag;
        negp_q <= a_s ^ b_s;
        p_q    <= '0;
        qq     <= dvd_mag;
        dq     <= dvr_mag;
        rq     <= '0;
        negq_q <= dvd_s ^ dvr_s;
        negr_q <= dvd_s;
        dzp_q  <= (dvr == '0);
        acc_q  <= acc_in;
        dvd_q  <= opa;
      end else if (busy_q) begin
        p_q  <= p_nx;
        mb_q <= mb_q << MB;
        rq   <= r_nx;
        qq   <= q_nx;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= fin_res;
          rem_q  <= fin_rem;
          ovf_q  <= fin_ovf;
          dz_q   <= dzp_q && ((op_q == OP_DIVS) || (op_q == OP_DIVL));
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign res  = res_q;
  assign rem  = rem_q;
  assign dz   = dz_q;
  assign ovf  = ovf_q;

  // ---------------- assertions ----------------
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_bad_op_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (op > 3'd4)) |=> !busy);

  assert_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(sgn_q) && $stable(dq) && $stable(acc_q)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res) && $stable(rem) && $stable(dz) && $stable(ovf)));

  assert_dz_value_R7: assert property (@(posedge clk) disable iff (rst)
    (done && dz) |-> ((res == '1) && (rem == dvd_q)));

  assert_clamp_R9: assert property (@(posedge clk) disable iff (rst)
    (done && (op_q == OP_MACS) && ovf) |->
      ((res == '1) || (res == {1'b0, {(W2-1){1'b1}}}) || (res == {1'b1, {(W2-1){1'b0}}})));
endmodule

// File: tb/arith_coproc_tb_top.sv
`timescale 1ns/1ps
module arith_coproc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        sgn = 1'b0;
  logic [31:0] opa = '0, opb = '0, acc_in = '0;
  logic        busy, done, dz, ovf;
  logic [31:0] res, rem;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  arith_coproc dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .sgn(sgn),
    .opa(opa), .opb(opb), .acc_in(acc_in),
    .busy(busy), .done(done), .res(res), .rem(rem), .dz(dz), .ovf(ovf)
  );

  logic [15:0] hv [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h7FFF, 16'h8000,
                           16'h8001, 16'hFFFF, 16'hFFFE, 16'h1234, 16'h00FF, 16'h5555};
  logic [31:0] av [5]  = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
  logic [31:0] dv [9]  = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0007, 32'h8000_0000, 32'h7FFF_FFFF,
                           32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'h1234_5678, 32'h0000_0040};
  logic [31:0] sv [9]  = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0007, 32'hFFFF_FFF9,
                           32'h0000_0002, 32'h8000_0000, 32'h0000_FFFF, 32'h1234_5678};

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic run_op(input logic [2:0] o, input logic s, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c, input bit poke);
    longint pa, pb, p, ac, sm, dd, ds, q, r;
    logic [31:0] eres, erem;
    logic edz, eovf;
    int lat, n, guard;
    string tag;
    eres = '0; erem = '0; edz = 1'b0; eovf = 1'b0; lat = 4; tag = "R4";
    pa = s ? longint'($signed(a[15:0])) : longint'(a[15:0]);
    pb = s ? longint'($signed(b[15:0])) : longint'(b[15:0]);
    p  = pa * pb;
    case (o)
      3'd0: eres = p[31:0];
      3'd1, 3'd2: begin
        lat = (o == 3'd1) ? 8 : 16;
        tag = s ? "R6" : "R5";
        dd = s ? longint'($signed(a)) : longint'(a);
        if (o == 3'd1) ds = s ? longint'($signed(b[15:0])) : longint'(b[15:0]);
        else           ds = s ? longint'($signed(b)) : longint'(b);
        if (ds == 0) begin
          tag = "R7"; eres = 32'hFFFF_FFFF; erem = a; edz = 1'b1;
        end else begin
          q = dd / ds; r = dd % ds;
          eres = q[31:0]; erem = r[31:0];
          eovf = s && (q > 64'sd2147483647);
        end
      end
      default: begin
        tag = (o == 3'd3) ? "R8" : "R9";
        ac = s ? longint'($signed(c)) : longint'(c);
        sm = p + ac;
        eovf = s ? ((sm > 64'sd2147483647) || (sm < -64'sd2147483648)) : (sm > 64'sd4294967295);
        eres = sm[31:0];
        if (o == 3'd4 && eovf) eres = !s ? 32'hFFFF_FFFF : (sm < 0 ? 32'h8000_0000 : 32'h7FFF_FFFF);
      end
    endcase

    @(negedge clk);
    op = o; sgn = s; opa = a; opb = b; acc_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble inputs after the start was taken
    op = ~o; sgn = ~s; opa = ~a; opb = b ^ 32'h5A5A_A5A5; acc_in = ~c;
    n = 0; guard = 0;
    while (!done && guard < 40) begin
      if (busy) n++;
      if (poke && n == 2) begin op = 3'd2; opb = 32'd3; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk("R2", "latency", 32'(n), 32'(lat));
    chk("R2", "busy at done", {31'b0, busy}, 32'd0);
    chk(poke ? "R10" : tag, "res", res, eres);
    chk(poke ? "R10" : tag, "rem", rem, erem);
    chk(tag, "dz", {31'b0, dz}, {31'b0, edz});
    chk(tag, "ovf", {31'b0, ovf}, {31'b0, eovf});
    @(negedge clk);
    chk("R2", "done one cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] keep_r, keep_m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "res", res, 32'd0);
    chk("R1", "rem", rem, 32'd0);
    chk("R1", "flags", {30'b0, dz, ovf}, 32'd0);

    // R4, R8, R9 sweeps
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int s = 0; s < 2; s++) begin
          run_op(3'd0, s[0], {16'hA5A5, hv[i]}, {16'h3C3C, hv[j]}, 32'h0, 1'b0);
          for (int k = 0; k < 5; k++) begin
            run_op(3'd3, s[0], {16'h0, hv[i]}, {16'h0, hv[j]}, av[k], 1'b0);
            run_op(3'd4, s[0], {16'h0, hv[i]}, {16'h0, hv[j]}, av[k], 1'b0);
          end
        end

    // R5, R6, R7 division sweeps
    for (int i = 0; i < 9; i++)
      for (int j = 0; j < 9; j++)
        for (int s = 0; s < 2; s++) begin
          run_op(3'd1, s[0], dv[i], sv[j], 32'h0, 1'b0);
          run_op(3'd2, s[0], dv[i], sv[j], 32'h0, 1'b0);
        end

    // random spread over all operations
    for (int t = 0; t < 300; t++)
      run_op(3'($urandom_range(4, 0)), 1'($urandom), $urandom, $urandom, $urandom, 1'b0);

    // R7: dz then a multiply clears it (checked inside run_op)
    run_op(3'd2, 1'b1, 32'h8000_0000, 32'h0, 32'h0, 1'b0);
    run_op(3'd0, 1'b0, 32'h3, 32'h5, 32'h0, 1'b0);
    // R6 edge: most negative over -1
    run_op(3'd2, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 1'b0);
    run_op(3'd1, 1'b1, 32'h8000_0000, 32'h0000_FFFF, 32'h0, 1'b0);

    // R10: start issued mid-operation is ignored
    run_op(3'd0, 1'b1, 32'h0000_8000, 32'h0000_7FFF, 32'h0, 1'b1);
    run_op(3'd2, 1'b0, 32'd1000, 32'd7, 32'h0, 1'b1);

    // R11: results hold while idle
    keep_r = res; keep_m = rem;
    opa = 32'hDEAD_BEEF; opb = 32'h1;
    repeat (5) @(negedge clk);
    chk("R11", "res hold", res, keep_r);
    chk("R11", "rem hold", rem, keep_m);

    // R3: codes 5..7 ignored
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      op = 3'(c); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R3", "busy on bad code", {31'b0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R3", "done on bad code", {31'b0, done}, 32'd0);
      chk("R3", "res on bad code", res, keep_r);
    end

    summary();
    $finish;
  end
endmodule